// File: doc/BRIEF.md
# Single-Wire Slave Bit Transceiver

This block is the bit-level slave side of a single-wire, open-drain bus that idles high through a pull-up. It watches a raw copy of the line, passes it through a synchronizer, and measures how long each low period lasts in microseconds. The microsecond tick comes from the system clock, whose frequency is a parameter. A low period that lasts long enough is taken as a bus reset. The block answers a reset with a presence pulse. Shorter low periods are bit slots, and the block samples each one a fixed time after its falling edge.

The block never drives the line high. Its only output to the bus is a pull-down enable. When the upper layer marks the next slot as a transmit slot with a zero bit, the block pulls the line low from the master's falling edge for a fixed time. Every slot, whether it is a write or a read, is also sampled and reported upward. This lets the upper layer use the same slot for both directions.

Toward the upper layer the block gives three one-cycle strobes. One marks a recognized reset. One marks a received bit and carries its value. One asks for the next bit to transmit, and it fires after each completed slot and after each presence pulse. Byte assembly, command decoding and bus powering belong to other blocks.

Top module: `sw_slave_phy`

## Requirements
- R1: After reset, `pull_o` is low and none of `rst_stb_o`, `bit_stb_o`, `tx_req_o` is asserted.
- R2: If the line stays low for RESET_US (default 480) microseconds after a falling edge, `rst_stb_o` pulses exactly once while the line is still low. The slot in progress is abandoned and gives no `tx_req_o`.
- R3: A low period shorter than RESET_US produces no `rst_stb_o` and no presence pulse.
- R4: After the line rises at the end of a reset, the block waits PRES_WAIT_US (default 30, within 15 to 60) microseconds. It then asserts `pull_o` for PRES_LOW_US (default 120, within 60 to 240) microseconds.
- R5: Every falling edge outside a reset sequence starts a slot. The line is sampled SAMPLE_US (default 30) microseconds after the edge, and `bit_stb_o` pulses with `bit_val_o` = 1 for a high line and 0 for a low line.
- R6: If `tx_drive_i`=1 and `tx_bit_i`=0 when the falling edge is seen, `pull_o` is asserted from the edge for HOLD_US (default 30) microseconds and then released, well before the 60 microsecond slot end.
- R7: If `tx_drive_i`=0, or `tx_bit_i`=1, the block does not assert `pull_o` during the slot.
- R8: A transmit slot is reported like any other slot, so a transmitted zero comes back as `bit_val_o`=0 and a transmitted one as 1.
- R9: `tx_req_o` pulses once when a slot ends, which is when the line is high after the sample. It also pulses once when a presence pulse ends.
- R10: While the line stays high, no strobe of any kind is produced, however long the idle time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Raw, unsynchronized bus line level |
| pull_o | output | 1 | Open-drain pull-down enable (1 pulls the line low) |
| tx_drive_i | input | 1 | Next slot is a transmit slot |
| tx_bit_i | input | 1 | Bit to transmit in the next slot |
| tx_req_o | output | 1 | One-cycle request for the next transmit bit |
| bit_stb_o | output | 1 | One-cycle strobe: a slot bit was sampled |
| bit_val_o | output | 1 | Value of the sampled bit, valid with `bit_stb_o` |
| rst_stb_o | output | 1 | One-cycle strobe: bus reset recognized |

## Verification
The bench measures how long after the master's edge the sample is taken, and it holds a low just under the reset threshold. A design that counted from the wrong point, or compared against the wrong bound, would sample outside the 15 to 60 microsecond window or treat a long write-zero as a reset. The presence pulse is checked for its start delay and its width. The read-zero pull is checked for being low at 14 microseconds and released by 45 microseconds, which catches a pull that is too short or never released. A reset that starts during a transmit-zero slot must release the pull, raise a single reset strobe and raise no bit request until presence is done. A design that let the aborted slot finish normally would issue an extra request.

// File: rtl/sw_pkg.sv
package sw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_RST_WAIT,
    ST_PRES_WAIT,
    ST_PRES_LOW
  } sw_state_e;

endpackage

// File: rtl/sw_line_sync.sv
module sw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s_o,
  output logic fall_o
);

  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q[0] <= 1'b1;
    else        sh_q[0] <= line_i;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[g] <= 1'b1;
        else        sh_q[g] <= sh_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sh_q[STAGES-1];
  end

  assign line_s_o = sh_q[STAGES-1];
  assign fall_o   = prev_q & ~sh_q[STAGES-1];

  // R5: an edge pulse never lasts more than one cycle
  a_r5_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

endmodule

// File: rtl/sw_us_tick.sv
module sw_us_tick #(
  parameter int CLKS_PER_US = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);

  generate
    if (CLKS_PER_US > 1) begin : g_div
      localparam int CW = $clog2(CLKS_PER_US);
      localparam logic [CW-1:0] LAST = CW'(CLKS_PER_US - 1);
      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        if (clr_i)             cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                   cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick_o = (cnt_q == LAST) && !clr_i;

      // R5: ticks are spaced, so microsecond counts cannot run fast
      a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end else begin : g_pass
      assign tick_o = !clr_i;
    end
  endgenerate

endmodule

// File: rtl/sw_slot_fsm.sv
module sw_slot_fsm
  import sw_pkg::*;
#(
  parameter int RESET_US     = 480,
  parameter int PRES_WAIT_US = 30,
  parameter int PRES_LOW_US  = 120,
  parameter int SAMPLE_US    = 30,
  parameter int HOLD_US      = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_s_i,
  input  logic fall_i,
  input  logic tick_i,
  output logic tick_clr_o,
  input  logic tx_drive_i,
  input  logic tx_bit_i,
  output logic pull_o,
  output logic tx_req_o,
  output logic bit_stb_o,
  output logic bit_val_o,
  output logic rst_stb_o
);

  localparam int US_W = $clog2(RESET_US + PRES_LOW_US + PRES_WAIT_US + 1);
  localparam logic [US_W-1:0] RESET_C  = US_W'(RESET_US);
  localparam logic [US_W-1:0] PWAIT_C  = US_W'(PRES_WAIT_US);
  localparam logic [US_W-1:0] PLOW_C   = US_W'(PRES_LOW_US);
  localparam logic [US_W-1:0] SAMPLE_C = US_W'(SAMPLE_US);
  localparam logic [US_W-1:0] HOLD_C   = US_W'(HOLD_US);

  sw_state_e       state_q, state_d;
  logic [US_W-1:0] us_q, us_d, us_inc;
  logic            pull_q, pull_d;
  logic            sampled_q, sampled_d;
  logic            bval_q, bval_d;
  logic            bstb_q, bstb_d;
  logic            rstb_q, rstb_d;
  logic            req_q, req_d;
  logic            clr;

  assign us_inc = tick_i ? us_q + 1'b1 : us_q;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    us_d      = us_q;
    pull_d    = pull_q;
    sampled_d = sampled_q;
    bval_d    = bval_q;
    bstb_d    = 1'b0;
    rstb_d    = 1'b0;
    req_d     = 1'b0;
    clr       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fall_i) begin
          state_d   = ST_SLOT;
          us_d      = '0;
          clr       = 1'b1;
          pull_d    = tx_drive_i & ~tx_bit_i;
          sampled_d = 1'b0;
        end
      end
      ST_SLOT: begin
        us_d = us_inc;
        if (tick_i && us_inc == HOLD_C) pull_d = 1'b0;
        if (tick_i && us_inc == SAMPLE_C) begin
          bstb_d    = 1'b1;
          bval_d    = line_s_i;
          sampled_d = 1'b1;
        end
        if (sampled_q && line_s_i) begin
          state_d = ST_IDLE;
          req_d   = 1'b1;
        end else if (tick_i && us_inc == RESET_C && !line_s_i) begin
          state_d = ST_RST_WAIT;
          rstb_d  = 1'b1;
          pull_d  = 1'b0;
        end
      end
      ST_RST_WAIT: begin
        if (line_s_i) begin
          state_d = ST_PRES_WAIT;
          us_d    = '0;
          clr     = 1'b1;
        end
      end
      ST_PRES_WAIT: begin
        us_d = us_inc;
        if (tick_i && us_inc == PWAIT_C) begin
          state_d = ST_PRES_LOW;
          us_d    = '0;
          pull_d  = 1'b1;
        end
      end
      ST_PRES_LOW: begin
        us_d = us_inc;
        if (tick_i && us_inc == PLOW_C) begin
          state_d = ST_IDLE;
          pull_d  = 1'b0;
          req_d   = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        pull_d  = 1'b0;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      us_q      <= '0;
      pull_q    <= 1'b0;
      sampled_q <= 1'b0;
      bval_q    <= 1'b0;
      bstb_q    <= 1'b0;
      rstb_q    <= 1'b0;
      req_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      us_q      <= us_d;
      pull_q    <= pull_d;
      sampled_q <= sampled_d;
      bval_q    <= bval_d;
      bstb_q    <= bstb_d;
      rstb_q    <= rstb_d;
      req_q     <= req_d;
    end
  end

  assign tick_clr_o = clr;
  assign pull_o     = pull_q;
  assign tx_req_o   = req_q;
  assign bit_stb_o  = bstb_q;
  assign bit_val_o  = bval_q;
  assign rst_stb_o  = rstb_q;

  // R2: a reset is announced by a single pulse
  a_r2_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_stb_o |=> !rst_stb_o);

  // R2: the reset strobe is raised only when the line is still low
  a_r2_rst_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    rst_stb_o |-> state_q == ST_RST_WAIT);

  // R4: the presence pull never outlasts its width
  a_r4_pres_width: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRES_LOW) |-> us_q < PLOW_C);

  // R6: a transmit-zero pull is released once the hold time is reached
  a_r6_hold_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_o && state_q == ST_SLOT) |-> us_q < HOLD_C);

  // R5: the bit strobe arrives at the sample point of the slot
  a_r5_sample_point: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb_o |-> (us_q == SAMPLE_C && state_q != ST_PRES_LOW));

  // R9: a bit request is a single-cycle pulse
  a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_o |=> !tx_req_o);

  // R7: pulling in the idle state would corrupt the bus
  a_r7_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !pull_o);

endmodule

// File: rtl/sw_slave_phy.sv
module sw_slave_phy #(
  parameter int CLK_HZ       = 4_000_000,
  parameter int SYNC_STAGES  = 2,
  parameter int RESET_US     = 480,
  parameter int PRES_WAIT_US = 30,
  parameter int PRES_LOW_US  = 120,
  parameter int SAMPLE_US    = 30,
  parameter int HOLD_US      = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic pull_o,
  input  logic tx_drive_i,
  input  logic tx_bit_i,
  output logic tx_req_o,
  output logic bit_stb_o,
  output logic bit_val_o,
  output logic rst_stb_o
);

  localparam int CLKS_PER_US = CLK_HZ / 1_000_000;

  logic line_s;
  logic fall;
  logic tick;
  logic tick_clr;

  sw_line_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_i   (line_i),
    .line_s_o (line_s),
    .fall_o   (fall)
  );

  sw_us_tick #(
    .CLKS_PER_US (CLKS_PER_US)
  ) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (tick_clr),
    .tick_o (tick)
  );

  sw_slot_fsm #(
    .RESET_US     (RESET_US),
    .PRES_WAIT_US (PRES_WAIT_US),
    .PRES_LOW_US  (PRES_LOW_US),
    .SAMPLE_US    (SAMPLE_US),
    .HOLD_US      (HOLD_US)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_s_i   (line_s),
    .fall_i     (fall),
    .tick_i     (tick),
    .tick_clr_o (tick_clr),
    .tx_drive_i (tx_drive_i),
    .tx_bit_i   (tx_bit_i),
    .pull_o     (pull_o),
    .tx_req_o   (tx_req_o),
    .bit_stb_o  (bit_stb_o),
    .bit_val_o  (bit_val_o),
    .rst_stb_o  (rst_stb_o)
  );

  // R1: nothing is strobed during or straight after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !(rst_stb_o || bit_stb_o || tx_req_o));

  // R2: a reset and a bit are never reported in the same cycle
  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_stb_o && bit_stb_o));

endmodule

// File: tb/sw_slave_phy_bench.sv
`timescale 1ns/1ps
module sw_slave_phy_bench;

  localparam int CLK_PERIOD = 250;
  localparam int US = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_low = 1'b0;
  logic tx_drive = 1'b0;
  logic tx_bit = 1'b1;
  logic pull;
  logic line;
  logic tx_req, bit_stb, bit_val, rst_stb;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int cyc = 0;
  int n_rst = 0, n_bit = 0, n_req = 0, n_pull = 0;
  int last_val = 0, bit_cyc = 0, pr_rise = 0, pr_fall = 0;
  logic pull_prev = 1'b0;

  assign line = ~(master_low | pull);

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_slave_phy u_sw_slave_phy (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_i     (line),
    .pull_o     (pull),
    .tx_drive_i (tx_drive),
    .tx_bit_i   (tx_bit),
    .tx_req_o   (tx_req),
    .bit_stb_o  (bit_stb),
    .bit_val_o  (bit_val),
    .rst_stb_o  (rst_stb)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_stb) n_rst <= n_rst + 1;
    if (tx_req)  n_req <= n_req + 1;
    if (pull)    n_pull <= n_pull + 1;
    if (bit_stb) begin
      n_bit <= n_bit + 1;
      last_val <= int'(bit_val);
      bit_cyc <= cyc;
    end
    if (pull && !pull_prev) pr_rise <= cyc;
    if (!pull && pull_prev) pr_fall <= cyc;
    pull_prev <= pull;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_us(input int n);
    repeat (n * US) @(negedge clk);
  endtask

  task automatic t_reset_state();
    repeat (6) @(negedge clk);
    chk(pull == 1'b0, "R1 pull after reset", int'(pull), 0);
    chk(n_rst + n_bit + n_req == 0, "R1 strobes after reset", n_rst + n_bit + n_req, 0);
  endtask

  task automatic t_idle();
    int b = n_bit, r = n_rst, q = n_req;
    wait_us(2000);
    chk(n_bit == b && n_rst == r && n_req == q, "R10 idle quiet",
        (n_bit - b) + (n_rst - r) + (n_req - q), 0);
  endtask

  task automatic t_write(input bit v);
    int b = n_bit, q = n_req, p = n_pull, f;
    tx_drive = 1'b0; tx_bit = 1'b0;
    @(negedge clk);
    master_low = 1'b1; f = cyc;
    wait_us(v ? 5 : 60);
    master_low = 1'b0;
    wait_us(v ? 65 : 10);
    chk(n_bit == b + 1, "R5 write bit strobe", n_bit - b, 1);
    chk(last_val == int'(v), "R5 write bit value", last_val, int'(v));
    chk(bit_cyc - f >= 28 * US && bit_cyc - f <= 33 * US, "R5 sample time",
        bit_cyc - f, 30 * US);
    chk(n_pull == p, "R7 no pull in write slot", n_pull - p, 0);
    chk(n_req == q + 1, "R9 request after slot", n_req - q, 1);
  endtask

  task automatic t_read(input bit v);
    int b = n_bit, p = n_pull, q = n_req;
    tx_drive = 1'b1; tx_bit = v;
    @(negedge clk);
    master_low = 1'b1;
    wait_us(2);
    master_low = 1'b0;
    wait_us(12);
    chk(line == v, v ? "R7 read-one line at 14us" : "R6 read-zero line at 14us",
        int'(line), int'(v));
    wait_us(31);
    chk(pull == 1'b0, "R6 pull released by 45us", int'(pull), 0);
    wait_us(25);
    if (v) chk(n_pull == p, "R7 no pull for one", n_pull - p, 0);
    else   chk(n_pull - p >= 28 * US && n_pull - p <= 31 * US, "R6 hold length",
               n_pull - p, 30 * US);
    chk(n_bit == b + 1 && last_val == int'(v), "R8 read slot reported", last_val, int'(v));
    chk(n_req == q + 1, "R9 request after read slot", n_req - q, 1);
    tx_drive = 1'b0; tx_bit = 1'b1;
  endtask

  task automatic t_bus_reset(input bit during_read0);
    int r = n_rst, q = n_req, rel;
    tx_drive = during_read0; tx_bit = 1'b0;
    @(negedge clk);
    master_low = 1'b1;
    wait_us(490);
    chk(n_rst == r + 1, "R2 reset strobe while low", n_rst - r, 1);
    chk(pull == 1'b0, "R2 no pull while reset held", int'(pull), 0);
    chk(n_req == q, "R2 aborted slot gives no request", n_req - q, 0);
    tx_drive = 1'b0; tx_bit = 1'b1;
    master_low = 1'b0; rel = cyc;
    wait_us(300);
    chk(pr_rise - rel >= 15 * US && pr_rise - rel <= 60 * US, "R4 presence delay",
        pr_rise - rel, 30 * US);
    chk(pr_fall - pr_rise >= 60 * US && pr_fall - pr_rise <= 240 * US, "R4 presence width",
        pr_fall - pr_rise, 120 * US);
    chk(n_rst == r + 1, "R2 single reset strobe", n_rst - r, 1);
    chk(n_req == q + 1, "R9 request after presence", n_req - q, 1);
  endtask

  task automatic t_short_low();
    int r = n_rst, p = n_pull, b = n_bit;
    tx_drive = 1'b0;
    @(negedge clk);
    master_low = 1'b1;
    wait_us(400);
    master_low = 1'b0;
    wait_us(300);
    chk(n_rst == r, "R3 no reset under threshold", n_rst - r, 0);
    chk(n_pull == p, "R3 no presence under threshold", n_pull - p, 0);
    chk(n_bit == b + 1 && last_val == 0, "R3 long low is a zero", last_val, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_write(1'b1);
    t_write(1'b0);
    t_bus_reset(1'b0);
    t_read(1'b0);
    t_read(1'b1);
    t_write(1'b0);
    t_short_low();
    t_bus_reset(1'b1);
    t_idle();
    t_read(1'b0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule